// File: doc/BRIEF.md
# Supervisory Reset Generator

This block drives an active-low system reset for a processor subsystem. Three things can pull reset low: a supply monitor, a manual reset button line, and an expiry pulse from a watchdog. The supply monitor's comparators deliver two digital flags. One flag reports that the supply has dropped under the falling trip point. The other reports that the supply has climbed over the rising trip point, which sits a hysteresis step higher. All external inputs except the watchdog pulse are asynchronous and pass through two-flop synchronisers before use.

Reset is held low while the supply is considered bad or while a qualified manual press is in progress. When the last cause goes away, reset stays low for a further fixed number of clock cycles (`TIMEOUT_CYCLES`) before it is released. A watchdog pulse produces one such full-length reset. Any new cause that appears while reset is already low restarts that period from the beginning. Low pulses on the manual input that are shorter than `MR_FILTER_CYCLES` clock cycles are treated as noise and have no effect. A status output mirrors the reset so that the watchdog can hold itself cleared.

Top module: `sup_reset_gen`

## Requirements
- R1: When `supplyLowFlag` is high, `sysRstN` is low from the third rising clock edge after the flag rises, counting that edge, and it stays low for as long as the flag stays high.
- R2: Once the supply has been seen low, only `supplyOkFlag` ends the supply cause. With both flags low (supply between the two trip points), `sysRstN` stays low indefinitely. After `supplyOkFlag` rises, `sysRstN` goes high on the (TIMEOUT_CYCLES+2)-th rising edge.
- R3: Every release of `sysRstN` is preceded by at least `TIMEOUT_CYCLES` consecutive low cycles. The timeout is a parameter in clock cycles; the default is 20,000,000, which is 200 ms at 100 MHz.
- R4: A `wdExpire` pulse one cycle wide, driven high before edge k, makes `sysRstN` low after edge k and high again after edge k+TIMEOUT_CYCLES.
- R5: A new watchdog pulse that arrives while `sysRstN` is low restarts the full timeout, so release comes TIMEOUT_CYCLES+1 edges after the second pulse is driven.
- R6: `sysRstN` stays low while `manRstN` is held low. It goes high on the (TIMEOUT_CYCLES+3)-th rising edge after `manRstN` returns high.
- R7: A low pulse on `manRstN` lasting fewer than `MR_FILTER_CYCLES` clock cycles leaves `sysRstN` high. A pulse lasting `MR_FILTER_CYCLES` cycles or more causes a reset.
- R8: While `rstN` is low, `sysRstN` is low. After `rstN` is released, reset is not let go until `supplyOkFlag` has been seen high.
- R9: `resetActive` is always the inverse of `sysRstN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low power-on reset of the block itself |
| supplyLowFlag | input | 1 | High while the supply is under the falling trip point (asynchronous) |
| supplyOkFlag | input | 1 | High while the supply is over the rising trip point (asynchronous) |
| manRstN | input | 1 | Active-low manual reset request (asynchronous) |
| wdExpire | input | 1 | Synchronous one-cycle watchdog expiry pulse |
| sysRstN | output | 1 | Active-low system reset |
| resetActive | output | 1 | High while system reset is asserted |

## Verification
Two behaviours are the hardest to reach from the ports. The first is the band between the two trip points, where neither flag is set and the block must remember that the supply was bad. The bench gets there by dropping the low flag while keeping the ok flag clear, then holding that state for several timeout lengths. The second is the exact edge of the glitch filter. Table entries drive manual pulses one cycle below the filter length and exactly at it, then watch a full timeout window for any reset. Retriggering is reached by sending a second watchdog pulse halfway through a running timeout and timing the release from that second pulse.

// File: rtl/sup_rst_pkg.sv
package sup_rst_pkg;

  // Strobes from control to the timeout datapath
  typedef struct packed {
    logic load;   // reload the full timeout
    logic dec;    // count one cycle down
  } tmrStrobe_t;

  typedef enum logic {
    ST_LOW = 1'b0,   // system reset asserted
    ST_RUN = 1'b1    // system running
  } supState_t;

endpackage

// File: rtl/sup_rst_sync.sv
module sup_rst_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  generate
    if (STAGES <= 1) begin : g_single
      logic [WIDTH-1:0] stageQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ <= RST_VAL;
        else       stageQ <= din;
      end
      assign dout = stageQ;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] pipeQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipeQ <= {STAGES{RST_VAL}};
        else       pipeQ <= {pipeQ[STAGES-2:0], din};
      end
      assign dout = pipeQ[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/sup_rst_glitch_filter.sv
module sup_rst_glitch_filter #(
  parameter int MIN_LOW = 20
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinN,     // synchronised active-low request
  output logic held      // request qualified as a real press
);

  localparam int CW = (MIN_LOW < 2) ? 1 : $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] LAST = CW'(MIN_LOW - 1);

  logic [CW-1:0] lowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
      held   <= 1'b0;
    end else if (pinN) begin
      lowCnt <= '0;
      held   <= 1'b0;
    end else if (lowCnt == LAST) begin
      held   <= 1'b1;
    end else begin
      lowCnt <= lowCnt + 1'b1;
    end
  end

endmodule

// File: rtl/sup_rst_datapath.sv
module sup_rst_datapath
  import sup_rst_pkg::*;
#(
  parameter int TIMEOUT = 20_000_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  tmrStrobe_t strb,
  output logic       cntLast
);

  localparam int CW = (TIMEOUT < 2) ? 1 : $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] FULL = CW'(TIMEOUT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     cnt <= FULL;
    else if (strb.load)            cnt <= FULL;
    else if (strb.dec && cnt != 0) cnt <= cnt - 1'b1;
  end

  assign cntLast = (cnt == CW'(1));

endmodule

// File: rtl/sup_rst_ctrl.sv
module sup_rst_ctrl
  import sup_rst_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lowSync,
  input  logic       okSync,
  input  logic       mrHeld,
  input  logic       wdExpire,
  input  logic       cntLast,
  output tmrStrobe_t strb,
  output logic       sysRstN
);

  supState_t state;
  supState_t stateNxt;
  logic      badQ;
  logic      supplyBad;
  logic      holdSrc;

  // Hysteresis: set by the low flag, cleared only by the ok flag
  assign supplyBad = lowSync | (badQ & ~okSync);
  assign holdSrc   = supplyBad | mrHeld;

  always_comb begin
    strb.load = holdSrc | wdExpire;
    strb.dec  = (state == ST_LOW) & ~strb.load;
  end

  always_comb begin
    stateNxt = state;
    if (strb.load)                  stateNxt = ST_LOW;
    else if (strb.dec && cntLast)   stateNxt = ST_RUN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_LOW;
      badQ  <= 1'b1;
    end else begin
      state <= stateNxt;
      badQ  <= supplyBad;
    end
  end

  assign sysRstN = (state == ST_RUN);

endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen
  import sup_rst_pkg::*;
#(
  parameter int TIMEOUT_CYCLES   = 20_000_000,
  parameter int MR_FILTER_CYCLES = 20,
  parameter int SYNC_STAGES      = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyLowFlag,
  input  logic supplyOkFlag,
  input  logic manRstN,
  input  logic wdExpire,
  output logic sysRstN,
  output logic resetActive
);

  // bit 2: manual, bit 1: ok, bit 0: low. Reset state assumes a bad supply.
  localparam logic [2:0] SYNC_RST = 3'b101;

  logic [2:0] syncOut;
  logic       mrHeld;
  logic       cntLast;
  tmrStrobe_t strb;

  sup_rst_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SYNC_RST)
  ) sync_i (
    .clk (clk),
    .rstN(rstN),
    .din ({manRstN, supplyOkFlag, supplyLowFlag}),
    .dout(syncOut)
  );

  sup_rst_glitch_filter #(
    .MIN_LOW(MR_FILTER_CYCLES)
  ) mrFilt_i (
    .clk (clk),
    .rstN(rstN),
    .pinN(syncOut[2]),
    .held(mrHeld)
  );

  sup_rst_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .lowSync (syncOut[0]),
    .okSync  (syncOut[1]),
    .mrHeld  (mrHeld),
    .wdExpire(wdExpire),
    .cntLast (cntLast),
    .strb    (strb),
    .sysRstN (sysRstN)
  );

  sup_rst_datapath #(
    .TIMEOUT(TIMEOUT_CYCLES)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .cntLast(cntLast)
  );

  assign resetActive = ~sysRstN;

endmodule

// File: rtl/sup_reset_gen_chk.sv
module sup_reset_gen_chk #(
  parameter int TIMEOUT_CYCLES   = 20_000_000,
  parameter int MR_FILTER_CYCLES = 20
) (
  input logic clk,
  input logic rstN,
  input logic supplyLowFlag,
  input logic manRstN,
  input logic wdExpire,
  input logic sysRstN,
  input logic resetActive
);

  localparam int LW = $clog2(TIMEOUT_CYCLES + 1) + 1;
  localparam int MRLIM = MR_FILTER_CYCLES + 3;
  localparam int MW = $clog2(MRLIM + 1) + 1;

  logic [LW-1:0] lowRun;
  logic [MW-1:0] mrRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            lowRun <= '0;
    else if (sysRstN)                     lowRun <= '0;
    else if (lowRun < LW'(TIMEOUT_CYCLES)) lowRun <= lowRun + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 mrRun <= '0;
    else if (manRstN)          mrRun <= '0;
    else if (mrRun < MW'(MRLIM)) mrRun <= mrRun + 1'b1;
  end

  p_supply_low_r1: assert property (@(posedge clk) disable iff (!rstN)
    (supplyLowFlag && $past(supplyLowFlag) && $past(supplyLowFlag, 2)) |=> !sysRstN);

  p_full_timeout_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysRstN) |-> (lowRun >= LW'(TIMEOUT_CYCLES)));

  p_wd_forces_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    wdExpire |=> !sysRstN);

  p_mr_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!manRstN && mrRun >= MW'(MRLIM)) |-> !sysRstN);

  p_status_inverse_r9: assert property (@(posedge clk) disable iff (!rstN)
    resetActive != sysRstN);

  // R8: block reset holds the system reset low
  always_ff @(posedge clk) begin
    if (!rstN) begin
      a_por_low_r8: assert (!sysRstN);
    end
  end

endmodule

bind sup_reset_gen sup_reset_gen_chk #(
  .TIMEOUT_CYCLES  (TIMEOUT_CYCLES),
  .MR_FILTER_CYCLES(MR_FILTER_CYCLES)
) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .supplyLowFlag(supplyLowFlag),
  .manRstN      (manRstN),
  .wdExpire     (wdExpire),
  .sysRstN      (sysRstN),
  .resetActive  (resetActive)
);

// File: tb/sup_reset_gen_tb_top.sv
module sup_reset_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 40;
  localparam int MRF        = 5;
  localparam int WATCHDOG   = 150_000;

  logic clk = 1'b0;
  logic rstN;
  logic supplyLowFlag;
  logic supplyOkFlag;
  logic manRstN;
  logic wdExpire;
  logic sysRstN;
  logic resetActive;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sup_reset_gen #(
    .TIMEOUT_CYCLES  (TMO),
    .MR_FILTER_CYCLES(MRF)
  ) dut_i (
    .clk          (clk),
    .rstN         (rstN),
    .supplyLowFlag(supplyLowFlag),
    .supplyOkFlag (supplyOkFlag),
    .manRstN      (manRstN),
    .wdExpire     (wdExpire),
    .sysRstN      (sysRstN),
    .resetActive  (resetActive)
  );

  // Vector: {kind, width, expectReset}; kind 0 = manual low pulse, 1 = watchdog pulse
  localparam int NVEC = 7;
  localparam logic [10:0] VEC [NVEC] = '{
    {2'd0, 8'd1,          1'b0},
    {2'd0, 8'd3,          1'b0},
    {2'd0, 8'(MRF - 1),   1'b0},
    {2'd0, 8'(MRF),       1'b1},
    {2'd0, 8'(MRF + 7),   1'b1},
    {2'd1, 8'd1,          1'b1},
    {2'd0, 8'd2,          1'b0}
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Counts edges (the first already taken = startN) until sysRstN is seen high
  task automatic waitHigh(input int startN, input int limit, output int n);
    n = startN;
    while (!sysRstN && n < limit) begin
      step();
      n++;
    end
  endtask

  task automatic settle();
    int n;
    waitHigh(0, 4 * TMO, n);
    repeat (3) step();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    int highSeen;
    int lowSeen;
    rstN          = 1'b0;
    supplyLowFlag = 1'b1;
    supplyOkFlag  = 1'b0;
    manRstN       = 1'b1;
    wdExpire      = 1'b0;
    repeat (4) step();

    // R8 / R9: reset state
    chk("R8 reset holds sysRstN low", int'(sysRstN), 0);
    chk("R9 resetActive during reset", int'(resetActive), 1);

    // R2 / R8: supply between trip points keeps reset low
    rstN = 1'b1;
    supplyLowFlag = 1'b0;
    highSeen = 0;
    for (int i = 0; i < 3 * TMO; i++) begin
      step();
      if (sysRstN) highSeen = 1;
    end
    chk("R8 no release without ok flag", highSeen, 0);

    // R2 / R3: release timing after ok flag
    supplyOkFlag = 1'b1;
    waitHigh(0, 4 * TMO, n);
    chk("R2 release edges after ok flag", n, TMO + 2);
    chk("R9 resetActive when running", int'(resetActive), 0);
    repeat (5) step();

    // R7 / R4: vector table
    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][10:9] == 2'd0) begin
        manRstN = 1'b0;
        repeat (int'(VEC[v][8:1])) step();
        manRstN = 1'b1;
      end else begin
        wdExpire = 1'b1;
        step();
        wdExpire = 1'b0;
      end
      lowSeen = 0;
      for (int i = 0; i < TMO + MRF + 10; i++) begin
        if (!sysRstN) lowSeen = 1;
        step();
      end
      chk($sformatf("R7 vector %0d reset seen", v), lowSeen, int'(VEC[v][0]));
      settle();
    end

    // R4: watchdog pulse timing
    wdExpire = 1'b1;
    step();
    wdExpire = 1'b0;
    chk("R4 low right after watchdog pulse", int'(sysRstN), 0);
    waitHigh(1, 4 * TMO, n);
    chk("R4 release edges after watchdog pulse", n, TMO + 1);
    settle();

    // R5: retrigger restarts full period
    wdExpire = 1'b1;
    step();
    wdExpire = 1'b0;
    repeat (TMO / 2) step();
    wdExpire = 1'b1;
    step();
    wdExpire = 1'b0;
    waitHigh(1, 4 * TMO, n);
    chk("R5 release edges after second pulse", n, TMO + 1);
    settle();

    // R6: manual hold and release
    manRstN = 1'b0;
    repeat (MRF + 4) step();
    highSeen = 0;
    for (int i = 0; i < 3 * TMO; i++) begin
      step();
      if (sysRstN) highSeen = 1;
    end
    chk("R6 stays low while manual held", highSeen, 0);
    manRstN = 1'b1;
    waitHigh(0, 4 * TMO, n);
    chk("R6 release edges after manual release", n, TMO + 3);
    settle();

    // R1: supply drop reaction time
    supplyLowFlag = 1'b1;
    supplyOkFlag  = 1'b0;
    step();
    step();
    chk("R1 still high after two edges", int'(sysRstN), 1);
    step();
    chk("R1 low after third edge", int'(sysRstN), 0);
    highSeen = 0;
    for (int i = 0; i < 2 * TMO; i++) begin
      step();
      if (sysRstN) highSeen = 1;
    end
    chk("R1 stays low while supply low", highSeen, 0);

    // R2: hysteresis band after a drop
    supplyLowFlag = 1'b0;
    highSeen = 0;
    for (int i = 0; i < 2 * TMO; i++) begin
      step();
      if (sysRstN) highSeen = 1;
    end
    chk("R2 held in hysteresis band", highSeen, 0);
    supplyOkFlag = 1'b1;
    waitHigh(0, 4 * TMO, n);
    chk("R2 release edges after recovery", n, TMO + 2);
    chk("R9 inverse after recovery", int'(resetActive), int'(!sysRstN));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule